// File: doc/BRIEF.md
# Parallel EPROM Read-Cycle Controller

This block is a synchronous master that fetches single bytes from an asynchronous parallel EPROM. The EPROM has no clock: it presents a byte only while its active-low chip select and active-low output gate are both asserted, and only after fixed delays measured from the address, the chip select and the output gate. The controller turns those delays, given in nanoseconds, into whole clock cycles when it is elaborated. The conversion always rounds up.

A user asserts `req` with an address while `busy` is low. The controller then runs one fixed sequence. It drives the address and lowers chip select, so the device's long access path starts first. After a lead interval it lowers the output gate, which has the shorter access path. When both windows have elapsed it captures the bus and pulses `rvalid` with the byte. It then raises both controls together. The bus must float again before the device is selected once more, so the controller waits out a release interval before it takes the next request. Between reads chip select stays high and the device sits in its low-power standby state.

Top module: `rom_rd_ctrl`

## Requirements
- R1: After reset, `rom_ce_n` and `rom_oe_n` are 1, and `busy` and `rvalid` are 0.
- R2: Whenever `busy` is 0, `rom_ce_n` is 1, so the device idles in standby.
- R3: A `req` seen on a rising edge while `busy` is 0 is accepted. `busy` is 1 from the next cycle, and `rom_addr` carries the captured `addr` for the whole access.
- R4: `rom_oe_n` is never 0 while `rom_ce_n` is 1. After acceptance, `rom_ce_n` is low for LEAD cycles with `rom_oe_n` high, and only then does `rom_oe_n` fall.
- R5: `rom_oe_n` stays low for OEPH cycles. `rom_dq` is captured on the edge that ends that window, and `rvalid` is 1 for exactly one cycle with `rdata` equal to the captured byte. `rom_ce_n` is low for LEAD+OEPH cycles per access.
- R6: `rom_addr` does not change while `rom_ce_n` is low, so the data is captured before any address change.
- R7: On the capture edge `rom_ce_n` and `rom_oe_n` both rise. `rom_ce_n` then stays high for at least REL cycles before the next access. If `req` is held continuously, the next `rom_ce_n` fall comes exactly REL+1 cycles after the rise, and `busy` stays 1 throughout the release.
- R8: A `req` raised while `busy` is 1 is ignored. It changes neither the address nor the number of accesses, and no extra `rvalid` follows once it is dropped.
- R9: The cycle counts are rounded up from the clock period P. LEAD = ceil((TACC−TOE)/P). OEPH = max(ceil(TOE/P), ceil(TACC/P)−LEAD, 1). REL = ceil(TDF/P). With the defaults (P=10, TACC=55, TOE=30, TDF=30) this gives LEAD=3, OEPH=3, REL=3.
- R10: Addresses at both ends of the range (all zeros and all ones) are driven and read correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Read request, sampled while not busy |
| addr | input | AW | Byte address for the request |
| busy | output | 1 | Access or release in progress |
| rdata | output | DW | Byte fetched by the last access |
| rvalid | output | 1 | One-cycle strobe marking `rdata` as new |
| rom_addr | output | AW | Address to the EPROM |
| rom_ce_n | output | 1 | Active-low chip select to the EPROM |
| rom_oe_n | output | 1 | Active-low output gate to the EPROM |
| rom_dq | input | DW | EPROM data bus |

## Verification
The bench builds the block with its defaults: an 18-bit address, an 8-bit byte, a 10 ns clock, and the fastest timing grade of 55/30/30 ns. These values make the lead, output-gate and release windows three cycles each, which is long enough that an off-by-one in any single window changes the measured strobe lengths. The EPROM model in the bench returns an unknown byte until the address, chip-select and output-gate delays have all elapsed, so a controller that samples too early returns a wrong value. Back-to-back requests with `req` held high reach the shortest legal release gap.

// File: rtl/rom_rd_ctrl.sv
module rom_rd_ctrl #(
  parameter int AW       = 18,
  parameter int DW       = 8,
  parameter int CLK_NS   = 10,
  parameter int T_ACC_NS = 55,
  parameter int T_OE_NS  = 30,
  parameter int T_DF_NS  = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [AW-1:0] addr,
  output logic          busy,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic [AW-1:0] rom_addr,
  output logic          rom_ce_n,
  output logic          rom_oe_n,
  input  logic [DW-1:0] rom_dq
);

  localparam int ACC_CYC  = (T_ACC_NS + CLK_NS - 1) / CLK_NS;
  localparam int OE_CYC   = (T_OE_NS + CLK_NS - 1) / CLK_NS;
  localparam int LEAD_NS  = (T_ACC_NS > T_OE_NS) ? (T_ACC_NS - T_OE_NS) : 0;
  localparam int LEAD_CYC = (LEAD_NS + CLK_NS - 1) / CLK_NS;
  localparam int REST_CYC = ACC_CYC - LEAD_CYC;
  localparam int OEPH_A   = (REST_CYC > OE_CYC) ? REST_CYC : OE_CYC;
  localparam int OEPH_CYC = (OEPH_A > 1) ? OEPH_A : 1;
  localparam int DF_CYC   = (T_DF_NS + CLK_NS - 1) / CLK_NS;
  localparam int MAX_AB   = (LEAD_CYC > OEPH_CYC) ? LEAD_CYC : OEPH_CYC;
  localparam int MAX_CYC  = (MAX_AB > DF_CYC) ? MAX_AB : DF_CYC;
  localparam int CW       = $clog2(MAX_CYC + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_READ, ST_REL} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] a_q;
  logic [DW-1:0] d_q;
  logic          ce_q, oe_q, v_q;

  assign busy     = (st != ST_IDLE);
  assign rdata    = d_q;
  assign rvalid   = v_q;
  assign rom_addr = a_q;
  assign rom_ce_n = ce_q;
  assign rom_oe_n = oe_q;

  wire cnt_done = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      a_q  <= '0;
      d_q  <= '0;
      ce_q <= 1'b1;
      oe_q <= 1'b1;
      v_q  <= 1'b0;
    end else begin
      v_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req) begin
            a_q  <= addr;
            ce_q <= 1'b0;
            if (LEAD_CYC == 0) begin
              st   <= ST_READ;
              oe_q <= 1'b0;
              cnt  <= CW'(OEPH_CYC - 1);
            end else begin
              st  <= ST_LEAD;
              cnt <= CW'(LEAD_CYC - 1);
            end
          end
        end
        ST_LEAD: begin
          if (cnt_done) begin
            st   <= ST_READ;
            oe_q <= 1'b0;
            cnt  <= CW'(OEPH_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_READ: begin
          if (cnt_done) begin
            d_q  <= rom_dq;
            v_q  <= 1'b1;
            ce_q <= 1'b1;
            oe_q <= 1'b1;
            if (DF_CYC == 0) begin
              st <= ST_IDLE;
            end else begin
              st  <= ST_REL;
              cnt <= CW'(DF_CYC - 1);
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt_done) st <= ST_IDLE;
          else          cnt <= cnt - 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/rom_rd_chk.sv
module rom_rd_chk #(
  parameter int AW     = 18,
  parameter int DF_CYC = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          busy,
  input logic          rvalid,
  input logic [AW-1:0] rom_addr,
  input logic          rom_ce_n,
  input logic          rom_oe_n
);

  localparam int GW = $clog2(DF_CYC + 2) + 1;

  logic [GW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             hi_cnt <= GW'(DF_CYC);
    else if (!rom_ce_n)     hi_cnt <= '0;
    else if (hi_cnt < GW'(DF_CYC)) hi_cnt <= hi_cnt + 1'b1;
  end

  AST_OE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_oe_n |-> !rom_ce_n); // R4

  AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> rom_ce_n); // R2

  AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy) |=> (busy && !rom_ce_n)); // R3

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_ce_n && $past(!rom_ce_n)) |-> $stable(rom_addr)); // R6

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> (rom_ce_n && rom_oe_n && busy == (DF_CYC != 0)) ##1 !rvalid); // R5

  AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rom_ce_n) |-> (hi_cnt >= GW'(DF_CYC))); // R7

endmodule

bind rom_rd_ctrl rom_rd_chk #(.AW(AW), .DF_CYC(DF_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .busy(busy), .rvalid(rvalid),
  .rom_addr(rom_addr), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n)
);

// File: tb/rom_rd_ctrl_tb.sv
`timescale 1ns/1ps
module rom_rd_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 18;
  localparam int DW = 8;
  localparam int T_ACC = 55;
  localparam int T_OE  = 30;
  localparam int T_DF  = 30;
  // R9: expected window lengths for the defaults
  localparam int E_LEAD = 3;
  localparam int E_OEPH = 3;
  localparam int E_REL  = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          busy, rvalid, rom_ce_n, rom_oe_n;
  logic [DW-1:0] rdata;
  logic [AW-1:0] rom_addr;
  logic [DW-1:0] rom_dq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  rom_rd_ctrl #(.AW(AW), .DW(DW), .CLK_NS(CLK_PERIOD), .T_ACC_NS(T_ACC),
                .T_OE_NS(T_OE), .T_DF_NS(T_DF)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .busy(busy),
    .rdata(rdata), .rvalid(rvalid), .rom_addr(rom_addr),
    .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n), .rom_dq(rom_dq));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] pattern(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {6'b0, a[17:16]} ^ 8'h5A;
  endfunction

  // EPROM model: unknown until every access delay has elapsed
  realtime t_ce = 0.0, t_oe = 0.0, t_a = 0.0;
  always @(negedge rom_ce_n) t_ce = $realtime;
  always @(negedge rom_oe_n) t_oe = $realtime;
  always @(rom_addr)         t_a  = $realtime;
  initial begin
    rom_dq = 'z;
    forever begin
      #0.5;
      if (rom_ce_n || rom_oe_n) rom_dq = 'z;
      else if (($realtime - t_ce >= T_ACC - 1) && ($realtime - t_a >= T_ACC - 1) &&
               ($realtime - t_oe >= T_OE - 1)) rom_dq = pattern(rom_addr);
      else rom_dq = 'x;
    end
  end

  // strobe monitor, sampled between edges
  int ce_run = 0, ce_last = 0, oe_run = 0, oe_last = 0;
  int lead_run = 0, lead_last = 0, gap_run = 100, gap_last = 0;
  int viol = 0, nvalid = 0;
  logic [AW-1:0] held_addr = '0;
  always @(posedge clk) begin
    #3;
    if (!rom_oe_n && rom_ce_n) viol++;
    if (!rom_ce_n) begin
      if (ce_run == 0) gap_last = gap_run;
      else if (rom_addr != held_addr) viol++;
      held_addr = rom_addr;
      gap_run = 0;
      ce_run++;
    end else begin
      if (ce_run != 0) ce_last = ce_run;
      ce_run = 0;
      gap_run++;
    end
    if (!rom_oe_n) begin
      if (oe_run == 0) lead_last = lead_run;
      oe_run++;
    end else begin
      if (oe_run != 0) oe_last = oe_run;
      oe_run = 0;
    end
    if (!rom_ce_n && rom_oe_n) lead_run++;
    else if (rom_ce_n) lead_run = 0;
    if (rvalid) nvalid++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
        finish_run();
      end
    end
  end

  // one read with req dropped after acceptance; returns latency in negedges
  task automatic one_read(input logic [AW-1:0] a, output int lat);
    @(negedge clk);
    req = 1'b1; addr = a; lat = 0;
    do begin
      @(negedge clk); lat++;
      if (busy) req = 1'b0;
    end while (!rvalid && lat < 50);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(rom_ce_n === 1'b1, "R1 ce_n", rom_ce_n, 1);
    check(rom_oe_n === 1'b1, "R1 oe_n", rom_oe_n, 1);
    check(busy === 1'b0, "R1 busy", busy, 0);
    check(rvalid === 1'b0, "R1 rvalid", rvalid, 0);
  endtask

  task automatic t_single(input logic [AW-1:0] a, input string tag);
    int lat;
    int v0;
    v0 = nvalid;
    one_read(a, lat);
    check(lat == E_LEAD + E_OEPH + 1, {tag, " R5 latency"}, lat, E_LEAD + E_OEPH + 1);
    check(rdata === pattern(a), {tag, " R5 rdata"}, rdata, pattern(a));
    check(rom_addr == a, {tag, " R3 rom_addr"}, rom_addr, a);
    check(lead_last == E_LEAD, {tag, " R4 lead"}, lead_last, E_LEAD);
    check(oe_last == E_OEPH, {tag, " R5 oe window"}, oe_last, E_OEPH);
    check(ce_last == E_LEAD + E_OEPH, {tag, " R5 ce window"}, ce_last, E_LEAD + E_OEPH);
    @(negedge clk);
    check(rvalid === 1'b0, {tag, " R5 pulse"}, rvalid, 0);
    check(busy === 1'b1 && rom_ce_n && rom_oe_n, {tag, " R7 release busy"}, busy, 1);
    repeat (E_REL + 2) @(negedge clk);
    check(busy === 1'b0 && rom_ce_n === 1'b1, {tag, " R2 standby"}, rom_ce_n, 1);
    check(nvalid - v0 == 1, {tag, " R5 one strobe"}, nvalid - v0, 1);
  endtask

  task automatic t_back_to_back();
    logic [AW-1:0] a1, a2;
    int n;
    a1 = 18'h1234A; a2 = 18'h2BCD5;
    @(negedge clk);
    req = 1'b1; addr = a1;
    @(negedge clk);
    addr = a2;
    n = 0;
    while (!rvalid && n < 50) begin @(negedge clk); n++; end
    check(rdata === pattern(a1), "R7 b2b first", rdata, pattern(a1));
    n = 0;
    do begin @(negedge clk); n++; end while (!rvalid && n < 50);
    req = 1'b0;
    check(rdata === pattern(a2), "R7 b2b second", rdata, pattern(a2));
    check(gap_last == E_REL + 1, "R7 gap", gap_last, E_REL + 1);
    repeat (E_REL + 3) @(negedge clk);
  endtask

  task automatic t_ignore_busy();
    logic [AW-1:0] a;
    int v0, n;
    a = 18'h00F0F; v0 = nvalid;
    @(negedge clk);
    req = 1'b1; addr = a;
    @(negedge clk);
    req = 1'b0; addr = 18'h3C3C3;
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
    n = 0;
    while (!rvalid && n < 50) begin @(negedge clk); n++; end
    check(rdata === pattern(a), "R8 data of first", rdata, pattern(a));
    check(rom_addr == a, "R8 address kept", rom_addr, a);
    repeat (12) @(negedge clk);
    check(nvalid - v0 == 1, "R8 no extra read", nvalid - v0, 1);
    check(rom_ce_n === 1'b1, "R8 R2 idle", rom_ce_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_single(18'h0A5C3, "basic");
    t_single(18'h00000, "R10 low");
    t_single(18'h3FFFF, "R10 high");
    t_single(18'h15555, "alt");
    t_back_to_back();
    t_ignore_busy();
    check(viol == 0, "R4 R6 strobe order and address hold", viol, 0);
    finish_run();
  end
endmodule